// File: doc/BRIEF.md
# Two-Word Instruction Fetch Unit

This block is the front end of a small in-order core with a separate program memory. Program memory is 16 bits wide and reads synchronously: an address driven in one cycle returns its word in the next cycle. The block drives the program counter out as the read address. It latches the first word of each instruction into a one-word instruction register and tells the execute stage when that register holds a complete instruction.

Most instructions are a single word. A long jump and a long call are two words. Their first word carries the opcode and the upper six bits of a 22-bit destination. Their second word carries the lower sixteen bits and is never decoded. The block fetches that second word one cycle later and routes it past the instruction register. It joins the word to the six bits held in the register and loads the result into the program counter. For a call, it also presents the address of the word after the second word on a strobed output, so that a stack outside the block can push it. A stall input holds the whole unit still.

Top module: `fetch_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the unit resets as follows: `pm_addr` becomes 0, `ir_valid` and `call_strobe` go low, `ret_addr` becomes 0 and the next word taken is a first word.
- R2: On every unstalled edge `pm_addr` advances by one, except at a target load. A first word read from address A appears in `ir` two edges after `pm_addr` showed A.
- R3: A first word whose bits [15:6] equal 10'h3D0 (long jump) or 10'h3D1 (long call) is a two-word instruction. It is latched into `ir` with `ir_valid` low. Any other first word is latched with `ir_valid` high.
- R4: During the fetch of the second word, `ir` keeps the first word unchanged. It still holds that word in the cycle in which the instruction completes.
- R5: At the edge that takes the second word, `pm_addr` becomes {first word bits [5:0], second word} and `ir_valid` goes high.
- R6: The read that is issued in the same cycle as the second word is taken gets discarded. In the cycle after a target load, `ir_valid` is low.
- R7: The second word is treated only as address data. Even when it matches a long-call or long-jump pattern, it causes no strobe and no further fetch of a second word.
- R8: At the completion of a long call, `call_strobe` is high for one cycle and `ret_addr` equals the second word's address plus one. A long jump leaves `call_strobe` low and `ret_addr` unchanged.
- R9: While `stall` is high, the following do not change at the clock edge: `pm_addr`, `ir`, `ir_valid`, `call_strobe`, `ret_addr` and the fetch state. `pm_ren` is low. A word already returned is taken once the stall is released.
- R10: A reset during the fetch of a second word discards the partial instruction. Fetching restarts at address 0 with a first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Holds the program counter, instruction register and fetch state |
| pm_ren | output | 1 | Program memory read enable (low during stall) |
| pm_addr | output | 22 | Program memory word address (the program counter) |
| pm_rdata | input | 16 | Word returned one cycle after its address |
| ir | output | 16 | Instruction register: first word of the current instruction |
| ir_valid | output | 1 | `ir` holds a completely fetched instruction |
| call_strobe | output | 1 | A long call completed this cycle |
| ret_addr | output | 22 | Return address of the most recent long call |

## Verification
The bench puts a stall in the middle of a two-word instruction. A unit that let the held memory word slip, or that advanced its state, would build a wrong destination or lose the first word. It checks the empty cycle after every target load: a unit that executed the read issued alongside the second word would show `ir_valid` high with a stale word. A long jump is given a second word that matches the long-call pattern. A unit that decoded it would raise `call_strobe` or wait for a third word. A call placed at a high address checks that `ret_addr` is built from the second word's own address and not from the destination. A reset taken halfway through a two-word instruction must leave no trace of it.

// File: rtl/ifu_pkg.sv
// Package: ifu_pkg
// Shared constants and the fetch-state type of the instruction fetch unit.
// Assumes the destination address is exactly one word plus the address
// bits that the first word carries.
package ifu_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 22;
    localparam int MSB_W  = ADDR_W - WORD_W;
    localparam int OPC_W  = WORD_W - MSB_W;

    localparam logic [OPC_W-1:0] OPC_LJMP  = 10'h3D0;
    localparam logic [OPC_W-1:0] OPC_LCALL = 10'h3D1;

    // HEAD: the next word taken is a first word; TAIL: it is operand data
    typedef enum logic {
        FS_HEAD = 1'b0,
        FS_TAIL = 1'b1
    } fetch_state_e;
endpackage

// File: rtl/ifu_opclass.sv
// Module: ifu_opclass
// Classifies one word as a first word: a long jump, a long call or neither.
// Purely combinational. Assumes the opcode sits in the upper OPC_W bits.
module ifu_opclass #(
    parameter int WORD_W = ifu_pkg::WORD_W,
    parameter int OPC_W  = ifu_pkg::OPC_W,
    parameter logic [OPC_W-1:0] OPC_LJMP  = ifu_pkg::OPC_LJMP,
    parameter logic [OPC_W-1:0] OPC_LCALL = ifu_pkg::OPC_LCALL
) (
    input  logic [WORD_W-1:0] word,
    output logic              is_long,
    output logic              is_call
);
    logic [OPC_W-1:0] opc;

    // Compare the opcode field against both two-word patterns
    always_comb begin
        opc     = word[WORD_W-1 -: OPC_W];
        is_call = (opc == OPC_LCALL);
        is_long = is_call || (opc == OPC_LJMP);
    end
endmodule

// File: rtl/ifu_pc.sv
// Module: ifu_pc
// Program counter register. It advances by one on every enabled cycle, or it
// takes a full destination address when load is high.
// Assumes load is only asserted together with adv.
module ifu_pc #(
    parameter int ADDR_W = ifu_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              load,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc
);
    // Hold, increment or load the program counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else if (adv)
            pc <= load ? target : pc + ADDR_W'(1);
    end
endmodule

// File: rtl/ifu_ctrl.sv
// Module: ifu_ctrl
// Fetch state machine and instruction register. It takes each returned word
// either as a first word (into the register) or as second-word address data
// (around the register), and builds the destination and return address.
// Assumes a synchronous memory whose output holds while the unit is stalled.
module ifu_ctrl #(
    parameter int WORD_W = ifu_pkg::WORD_W,
    parameter int ADDR_W = ifu_pkg::ADDR_W,
    parameter int MSB_W  = ifu_pkg::MSB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [ADDR_W-1:0] pc,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] ir,
    output logic              ir_valid,
    output logic              call_strobe,
    output logic [ADDR_W-1:0] ret_addr,
    output logic              load,
    output logic [ADDR_W-1:0] target
);
    import ifu_pkg::*;

    fetch_state_e      state;
    logic              rd_pend;
    logic [ADDR_W-1:0] addr_q;
    logic              head_long;
    logic              head_call;
    logic              ir_long;
    logic              ir_call;
    logic              take_tail;

    ifu_opclass u_cls_rdata (
        .word    (rdata),
        .is_long (head_long),
        .is_call (head_call)
    );

    ifu_opclass u_cls_ir (
        .word    (ir),
        .is_long (ir_long),
        .is_call (ir_call)
    );

    // Build the destination from held upper bits and the incoming data word
    always_comb begin
        take_tail = rd_pend && (state == FS_TAIL);
        load      = adv && take_tail;
        target    = {ir[MSB_W-1:0], rdata};
    end

    // Track which address the word in flight belongs to, and whether it counts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            addr_q  <= '0;
        end else if (adv) begin
            rd_pend <= !take_tail;
            addr_q  <= pc;
        end
    end

    // Latch first words, step the fetch state and raise the completion flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= FS_HEAD;
            ir          <= '0;
            ir_valid    <= 1'b0;
            call_strobe <= 1'b0;
            ret_addr    <= '0;
        end else if (adv) begin
            call_strobe <= 1'b0;
            if (!rd_pend) begin
                ir_valid <= 1'b0;
            end else if (state == FS_HEAD) begin
                ir       <= rdata;
                ir_valid <= !head_long;
                state    <= head_long ? FS_TAIL : FS_HEAD;
            end else begin
                ir_valid <= 1'b1;
                state    <= FS_HEAD;
                if (ir_call) begin
                    call_strobe <= 1'b1;
                    ret_addr    <= addr_q + ADDR_W'(1);
                end
            end
        end
    end

    // R3
    tail_needs_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_TAIL) |-> ir_long);
    // R4
    ir_hold_in_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_TAIL) |=> $stable(ir));
    // R3
    long_head_not_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && rd_pend && state == FS_HEAD && head_long) |=> (!ir_valid && state == FS_TAIL));
    // R7
    tail_no_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && take_tail) |=> (state == FS_HEAD && call_strobe == $past(ir_call)));

    logic unused_ok;
    assign unused_ok = head_call;
endmodule

// File: rtl/fetch_unit.sv
// Module: fetch_unit
// Top of the instruction fetch unit: program counter, fetch state machine and
// instruction register for a 16-bit synchronous program memory with two-word
// long jump and long call. Assumes the memory returns the word of the address
// shown on pm_addr in the following cycle, and holds it while pm_ren is low.
module fetch_unit #(
    parameter int WORD_W = ifu_pkg::WORD_W,
    parameter int ADDR_W = ifu_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    output logic              pm_ren,
    output logic [ADDR_W-1:0] pm_addr,
    input  logic [WORD_W-1:0] pm_rdata,
    output logic [WORD_W-1:0] ir,
    output logic              ir_valid,
    output logic              call_strobe,
    output logic [ADDR_W-1:0] ret_addr
);
    import ifu_pkg::*;

    logic              adv;
    logic              load;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] pc;

    // Every unstalled cycle reads the next word
    always_comb begin
        adv     = !stall;
        pm_ren  = adv;
        pm_addr = pc;
    end

    ifu_pc #(.ADDR_W(ADDR_W)) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .load   (load),
        .target (target),
        .pc     (pc)
    );

    ifu_ctrl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv         (adv),
        .pc          (pc),
        .rdata       (pm_rdata),
        .ir          (ir),
        .ir_valid    (ir_valid),
        .call_strobe (call_strobe),
        .ret_addr    (ret_addr),
        .load        (load),
        .target      (target)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pm_addr == '0 && !ir_valid && !call_strobe && ret_addr == '0));
    // R9
    stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(pm_addr) && $stable(ir) && $stable(ir_valid) && $stable(call_strobe)));
    // R8
    strobe_is_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
        call_strobe |-> (ir_valid && ir[WORD_W-1 -: OPC_W] == OPC_LCALL));
    // R6
    squash_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_strobe && !stall) |=> !ir_valid);
    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !load) |=> (pm_addr == $past(pm_addr) + ADDR_W'(1)));
endmodule

// File: tb/tb_fetch_unit.sv
`timescale 1ns/1ps
module tb_fetch_unit;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 22;

    typedef struct packed {
        logic              stall;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] ir;
        logic              vld;
        logic              cs;
        logic [ADDR_W-1:0] ret;
    } vec_t;

    // One row per clock edge after reset release: stall for that edge, then
    // expected pm_addr, ir, ir_valid, call_strobe, ret_addr after it
    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 22'h000001, 16'h0000, 1'b0, 1'b0, 22'h0},      // R2 first read in flight
        '{1'b0, 22'h000002, 16'h1111, 1'b1, 1'b0, 22'h0},      // R2
        '{1'b0, 22'h000003, 16'h2222, 1'b1, 1'b0, 22'h0},      // R2
        '{1'b0, 22'h000004, 16'hF441, 1'b0, 1'b0, 22'h0},      // R3 call head
        '{1'b1, 22'h000004, 16'hF441, 1'b0, 1'b0, 22'h0},      // R9 R4 stalled tail
        '{1'b1, 22'h000004, 16'hF441, 1'b0, 1'b0, 22'h0},      // R9
        '{1'b0, 22'h010020, 16'hF441, 1'b1, 1'b1, 22'h000004}, // R5 R8 R4
        '{1'b0, 22'h010021, 16'hF441, 1'b0, 1'b0, 22'h000004}, // R6 bubble
        '{1'b0, 22'h010022, 16'h5555, 1'b1, 1'b0, 22'h000004}, // R2
        '{1'b0, 22'h010023, 16'hF400, 1'b0, 1'b0, 22'h000004}, // R3 jump head
        '{1'b0, 22'h000030, 16'hF400, 1'b1, 1'b0, 22'h000004}, // R5 R8 jump: no strobe
        '{1'b0, 22'h000031, 16'hF400, 1'b0, 1'b0, 22'h000004}, // R6
        '{1'b0, 22'h000032, 16'h6666, 1'b1, 1'b0, 22'h000004}, // R2
        '{1'b0, 22'h000033, 16'hF400, 1'b0, 1'b0, 22'h000004}, // R3
        '{1'b0, 22'h00F440, 16'hF400, 1'b1, 1'b0, 22'h000004}, // R7 call-shaped data
        '{1'b0, 22'h00F441, 16'hF400, 1'b0, 1'b0, 22'h000004}, // R6 R7
        '{1'b0, 22'h00F442, 16'h1111, 1'b1, 1'b0, 22'h000004}, // R2
        '{1'b1, 22'h00F442, 16'h1111, 1'b1, 1'b0, 22'h000004}, // R9 valid held
        '{1'b0, 22'h00F443, 16'h2222, 1'b1, 1'b0, 22'h000004}, // R9 held word taken
        '{1'b0, 22'h00F444, 16'hF441, 1'b0, 1'b0, 22'h000004}, // R3
        '{1'b0, 22'h010020, 16'hF441, 1'b1, 1'b1, 22'h00F444}  // R8 high return address
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              stall = 1'b0;
    logic              pm_ren;
    logic [ADDR_W-1:0] pm_addr;
    logic [WORD_W-1:0] pm_rdata = '0;
    logic [WORD_W-1:0] ir;
    logic              ir_valid;
    logic              call_strobe;
    logic [ADDR_W-1:0] ret_addr;
    logic [WORD_W-1:0] mem [64];
    int                n_chk = 0;
    int                n_fail = 0;
    bit                done = 1'b0;

    always #2.5 clk = ~clk;

    fetch_unit dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall       (stall),
        .pm_ren      (pm_ren),
        .pm_addr     (pm_addr),
        .pm_rdata    (pm_rdata),
        .ir          (ir),
        .ir_valid    (ir_valid),
        .call_strobe (call_strobe),
        .ret_addr    (ret_addr)
    );

    // Synchronous program memory, aliased on the low six address bits
    always @(posedge clk) begin
        if (pm_ren) pm_rdata <= mem[pm_addr[5:0]];
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
        mem[0]    = 16'h1111;
        mem[1]    = 16'h2222;
        mem[2]    = 16'hF441;   // long call, upper bits 01
        mem[3]    = 16'h0020;
        mem[4]    = 16'h4444;   // read issued with the second word, discarded
        mem[6'h20] = 16'h5555;
        mem[6'h21] = 16'hF400;  // long jump, upper bits 00
        mem[6'h22] = 16'h0030;
        mem[6'h30] = 16'h6666;
        mem[6'h31] = 16'hF400;
        mem[6'h32] = 16'hF440;  // data word shaped like a long call
        mem[6'h33] = 16'h7777;

        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "pm_addr", 32'(pm_addr), 32'h0);
        chk("R1", "ir_valid", 32'(ir_valid), 32'h0);
        chk("R1", "call_strobe", 32'(call_strobe), 32'h0);
        chk("R1", "ret_addr", 32'(ret_addr), 32'h0);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            stall = VEC[i].stall;
            #1;
            chk("R9", "pm_ren", 32'(pm_ren), 32'(!VEC[i].stall));
            @(negedge clk);
            chk("R2/R5", "pm_addr", 32'(pm_addr), 32'(VEC[i].addr));
            chk("R4", "ir", 32'(ir), 32'(VEC[i].ir));
            chk("R3/R6", "ir_valid", 32'(ir_valid), 32'(VEC[i].vld));
            chk("R8", "call_strobe", 32'(call_strobe), 32'(VEC[i].cs));
            chk("R8", "ret_addr", 32'(ret_addr), 32'(VEC[i].ret));
        end
        stall = 1'b0;

        // R10 reset halfway through a long jump
        repeat (3) @(negedge clk);
        chk("R10", "ir before reset", 32'(ir), 32'hF400);
        chk("R10", "ir_valid before reset", 32'(ir_valid), 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10", "pm_addr", 32'(pm_addr), 32'h0);
        chk("R10", "ir_valid", 32'(ir_valid), 32'h0);
        chk("R10", "ret_addr", 32'(ret_addr), 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10", "ir restart", 32'(ir), 32'h1111);
        chk("R10", "ir_valid restart", 32'(ir_valid), 32'h1);
        chk("R10", "pm_addr restart", 32'(pm_addr), 32'h2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule